// File: doc/BRIEF.md
# Fail-Safe Configuration Supervisor

This block supervises how an FPGA gets its configuration after power-up. It walks a set of user image slots in a parallel flash, reads a short header from each, and starts a configuration load from the first slot whose header is sound. If no user slot passes, it loads the protected fallback image held in slot 0. A user image can only stay in place if the host proves it is alive. After a user load completes, a watchdog window opens. The host closes it by writing three key words in order on a simple write port. If the window expires first, the supervisor reloads the fallback image. The fallback image always keeps the flash reachable from the host, so a broken user image can always be replaced.

Flash reads are asynchronous: the supervisor presents an address and samples the returned word in the same cycle. Slot k begins at word address k·2^SLOT_AW. Word 0 of a slot holds the magic word, word 1 a size word, and word 2 the checksum. The configuration engine is told which slot to load through a one-cycle start strobe, and it reports completion on a done input. Status outputs show the host the loaded slot, whether the fallback is in use, whether the watchdog is armed, and whether the supervisor has settled.

Top module: `cfg_supervisor`

## Requirements
- R1: While reset is asserted, cfg_start, stat_slot, stat_fallback, stat_wdog_armed and stat_running are all 0.
- R2: A user slot is valid when word 0 equals MAGIC and word 2 equals the bitwise inverse of (word 0 XOR word 1). Slots 1 to N_USER are examined in ascending order, and the first valid one is loaded. Loading means cfg_start is high for exactly one cycle with cfg_slot set to that slot number.
- R3: If no user slot is valid, the fallback is loaded: cfg_start pulses with cfg_slot = 0. After cfg_done the block reaches the running state with stat_fallback = 1, stat_slot = 0, and the watchdog not armed.
- R4: The cycle after cfg_done for a user load, stat_wdog_armed goes high. Without an unlock it stays high for exactly WDOG_CYCLES cycles, and the following cycle starts a fallback load (cfg_start = 1, cfg_slot = 0).
- R5: While armed, host writes of KEY0, KEY1 and KEY2, in that order, disarm the watchdog. Idle cycles may separate the writes. The cycle after the KEY2 write, stat_running = 1, stat_fallback = 0, and stat_slot still holds the loaded user slot.
- R6: A write with any value other than the expected key returns the sequence to its first step. The next write must be KEY0 again.
- R7: Host writes made while the watchdog is not armed do not advance the sequence. Keys written before arming do not count toward an unlock.
- R8: If the KEY2 write falls in the last armed cycle, the unlock takes priority over the timeout.
- R9: After a fallback load completes, the watchdog is never re-armed. Later host writes and cfg_done pulses leave the running fallback state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flash_addr | output | FLASH_AW | Flash word address being read |
| flash_rdata | input | DATA_W | Flash word returned for flash_addr in the same cycle |
| cfg_start | output | 1 | One-cycle strobe that starts a configuration load |
| cfg_slot | output | SLOT_W | Slot to load, valid while cfg_start is high |
| cfg_done | input | 1 | Configuration engine reports that the load has finished |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | DATA_W | Host write data (unlock keys) |
| stat_slot | output | SLOT_W | Slot currently loaded |
| stat_fallback | output | 1 | Fallback image is in use |
| stat_wdog_armed | output | 1 | Watchdog window is open |
| stat_running | output | 1 | Supervisor has settled in the running state |

## Verification
The bench builds the block with three user slots of sixteen words each, 16-bit words, and a watchdog window of 20 cycles. The short window makes full expiries and the last-cycle unlock race cheap to reach many times. Three slots are enough to cover every outcome of the scan order: the first slot wins, a later slot wins after rejections for a bad magic word and for a bad checksum, and every slot is rejected. Key sequences are then varied inside and outside the armed window.

// File: rtl/cfg_sup_pkg.sv
package cfg_sup_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCAN,
      ST_LOAD_USER,
      ST_WAIT_DONE,
      ST_WATCHDOG,
      ST_RUNNING,
      ST_LOAD_FB
   } sup_state_t;
endpackage

// File: rtl/cfg_hdr_check.sv
module cfg_hdr_check #(
   parameter int                DATA_W    = 16,
   parameter logic [DATA_W-1:0] MAGIC     = 16'hC0DE,
   parameter int                CHECK_SUM = 1
) (
   input  logic [DATA_W-1:0] w_magic,
   input  logic [DATA_W-1:0] w_size,
   input  logic [DATA_W-1:0] w_sum,
   output logic              hdr_ok
);
   generate
      if (CHECK_SUM != 0) begin : g_sum
         always_comb hdr_ok = (w_magic == MAGIC) && (w_sum == ~(w_magic ^ w_size));
      end else begin : g_magic_only
         logic [DATA_W-1:0] unused_w;
         assign unused_w = w_size ^ w_sum;
         always_comb hdr_ok = (w_magic == MAGIC);
      end
   endgenerate
endmodule

// File: rtl/cfg_unlock_match.sv
module cfg_unlock_match #(
   parameter int                DATA_W = 16,
   parameter logic [DATA_W-1:0] KEY0   = 16'h5A17,
   parameter logic [DATA_W-1:0] KEY1   = 16'hC3E8,
   parameter logic [DATA_W-1:0] KEY2   = 16'h0F96
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              hit
);
   logic [1:0]        step;
   logic [DATA_W-1:0] want;

   always_comb begin
      case (step)
         2'd0:    want = KEY0;
         2'd1:    want = KEY1;
         default: want = KEY2;
      endcase
   end

   assign hit = en && wr && (step == 2'd2) && (wdata == KEY2);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         step <= 2'd0;
      end else if (wr) begin
         if (wdata == want && step != 2'd2) step <= step + 2'd1;
         else                               step <= 2'd0;
      end
   end
endmodule

// File: rtl/cfg_wdog_timer.sv
module cfg_wdog_timer #(
   parameter int WDOG_CYCLES = 64,
   localparam int CW = (WDOG_CYCLES > 2) ? $clog2(WDOG_CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic expired
);
   logic [CW-1:0] cnt;

   assign expired = en && (cnt == CW'(WDOG_CYCLES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !en) cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/cfg_supervisor.sv
module cfg_supervisor
   import cfg_sup_pkg::*;
#(
   parameter int                DATA_W      = 16,
   parameter int                N_USER      = 3,
   parameter int                SLOT_AW     = 4,
   parameter int                WDOG_CYCLES = 64,
   parameter int                CHECK_SUM   = 1,
   parameter logic [DATA_W-1:0] MAGIC       = 16'hC0DE,
   parameter logic [DATA_W-1:0] KEY0        = 16'h5A17,
   parameter logic [DATA_W-1:0] KEY1        = 16'hC3E8,
   parameter logic [DATA_W-1:0] KEY2        = 16'h0F96,
   localparam int SLOT_W   = $clog2(N_USER + 1),
   localparam int FLASH_AW = SLOT_W + SLOT_AW
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [FLASH_AW-1:0] flash_addr,
   input  logic [DATA_W-1:0]   flash_rdata,
   output logic                cfg_start,
   output logic [SLOT_W-1:0]   cfg_slot,
   input  logic                cfg_done,
   input  logic                host_wr,
   input  logic [DATA_W-1:0]   host_wdata,
   output logic [SLOT_W-1:0]   stat_slot,
   output logic                stat_fallback,
   output logic                stat_wdog_armed,
   output logic                stat_running
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_USER);

   generate
      if (N_USER < 1)       begin : g_bad_nuser $error("N_USER must be at least 1"); end
      if (SLOT_AW < 2)      begin : g_bad_slot  $error("SLOT_AW must be at least 2"); end
      if (WDOG_CYCLES < 2)  begin : g_bad_wdog  $error("WDOG_CYCLES must be at least 2"); end
      if (DATA_W < 8)       begin : g_bad_width $error("DATA_W must be at least 8"); end
   endgenerate

   sup_state_t        state;
   logic [SLOT_W-1:0] slot_cnt;
   logic [1:0]        word_idx;
   logic [DATA_W-1:0] w_magic, w_size;
   logic [SLOT_W-1:0] active_slot;
   logic              fb_mode;
   logic              hdr_ok, unlock_hit, wdog_expired, armed;

   assign armed      = (state == ST_WATCHDOG);
   assign flash_addr = {slot_cnt, {(SLOT_AW-2){1'b0}}, word_idx};

   cfg_hdr_check #(.DATA_W(DATA_W), .MAGIC(MAGIC), .CHECK_SUM(CHECK_SUM)) i_hdr (
      .w_magic (w_magic),
      .w_size  (w_size),
      .w_sum   (flash_rdata),
      .hdr_ok  (hdr_ok)
   );

   cfg_unlock_match #(.DATA_W(DATA_W), .KEY0(KEY0), .KEY1(KEY1), .KEY2(KEY2)) i_match (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (armed),
      .wr    (host_wr),
      .wdata (host_wdata),
      .hit   (unlock_hit)
   );

   cfg_wdog_timer #(.WDOG_CYCLES(WDOG_CYCLES)) i_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (armed),
      .expired (wdog_expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         slot_cnt    <= '0;
         word_idx    <= '0;
         w_magic     <= '0;
         w_size      <= '0;
         active_slot <= '0;
         fb_mode     <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               slot_cnt <= SLOT_W'(1);
               word_idx <= '0;
               state    <= ST_SCAN;
            end
            ST_SCAN: begin
               if (word_idx == 2'd0) w_magic <= flash_rdata;
               if (word_idx == 2'd1) w_size  <= flash_rdata;
               if (word_idx == 2'd2) begin
                  word_idx <= '0;
                  if (hdr_ok)                     state    <= ST_LOAD_USER;
                  else if (slot_cnt == LAST_SLOT) state    <= ST_LOAD_FB;
                  else                            slot_cnt <= slot_cnt + 1'b1;
               end else begin
                  word_idx <= word_idx + 2'd1;
               end
            end
            ST_LOAD_USER: begin
               active_slot <= slot_cnt;
               fb_mode     <= 1'b0;
               state       <= ST_WAIT_DONE;
            end
            ST_LOAD_FB: begin
               active_slot <= '0;
               fb_mode     <= 1'b1;
               state       <= ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
               if (cfg_done) state <= fb_mode ? ST_RUNNING : ST_WATCHDOG;
            end
            ST_WATCHDOG: begin
               if (unlock_hit)        state <= ST_RUNNING;
               else if (wdog_expired) state <= ST_LOAD_FB;
            end
            ST_RUNNING: state <= ST_RUNNING;
            default:    state <= ST_IDLE;
         endcase
      end
   end

   assign cfg_start       = (state == ST_LOAD_USER) || (state == ST_LOAD_FB);
   assign cfg_slot        = (state == ST_LOAD_FB) ? '0 : slot_cnt;
   assign stat_slot       = active_slot;
   assign stat_fallback   = fb_mode;
   assign stat_wdog_armed = armed;
   assign stat_running    = (state == ST_RUNNING);
endmodule

// File: rtl/cfg_supervisor_chk.sv
module cfg_supervisor_chk #(
   parameter int                DATA_W      = 16,
   parameter int                SLOT_W      = 2,
   parameter int                WDOG_CYCLES = 64,
   parameter logic [DATA_W-1:0] KEY2        = 16'h0F96
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic [DATA_W-1:0] host_wdata,
   input logic              cfg_start,
   input logic [SLOT_W-1:0] cfg_slot,
   input logic [SLOT_W-1:0] stat_slot,
   input logic              stat_fallback,
   input logic              stat_wdog_armed,
   input logic              stat_running
);
   logic [31:0] armed_len;

   always_ff @(posedge clk) begin
      if (!rst_n || !stat_wdog_armed) armed_len <= '0;
      else                            armed_len <= armed_len + 32'd1;
   end

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !cfg_start && !stat_running); // R1
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cfg_start |=> !cfg_start); // R2
   AST_FB_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_fallback) |-> $past(cfg_start) && ($past(cfg_slot) == '0)); // R3
   AST_FB_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      stat_fallback && !cfg_start |-> stat_slot == '0); // R3
   AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wdog_armed |-> armed_len < WDOG_CYCLES); // R4
   AST_ARMED_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_wdog_armed) |-> stat_running || (cfg_start && cfg_slot == '0)); // R4
   AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_wdog_armed) && stat_running |-> $past(host_wr) && ($past(host_wdata) == KEY2)); // R5
   AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      stat_fallback |-> !stat_wdog_armed); // R9
   AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      stat_running |=> stat_running && $stable(stat_slot) && $stable(stat_fallback)); // R9
endmodule

bind cfg_supervisor cfg_supervisor_chk #(
   .DATA_W(DATA_W), .SLOT_W(SLOT_W), .WDOG_CYCLES(WDOG_CYCLES), .KEY2(KEY2)
) i_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .host_wr         (host_wr),
   .host_wdata      (host_wdata),
   .cfg_start       (cfg_start),
   .cfg_slot        (cfg_slot),
   .stat_slot       (stat_slot),
   .stat_fallback   (stat_fallback),
   .stat_wdog_armed (stat_wdog_armed),
   .stat_running    (stat_running)
);

// File: tb/test_cfg_supervisor.sv
module test_cfg_supervisor;
   localparam int          DW    = 16;
   localparam int          NU    = 3;
   localparam int          SAW   = 4;
   localparam int          W     = 20;
   localparam logic [15:0] MAGIC = 16'hC0DE;
   localparam logic [15:0] K0    = 16'h5A17;
   localparam logic [15:0] K1    = 16'hC3E8;
   localparam logic [15:0] K2    = 16'h0F96;

   // vector: [9:4] slot modes (slot3,slot2,slot1; 0 empty,1 valid,2 bad magic,3 bad sum),
   //         [3:2] first loaded slot, [1] unlock, [0] final fallback
   localparam logic [9:0] VEC [6] = '{
      10'b010101_01_1_0,
      10'b000110_10_1_0,
      10'b010011_11_0_1,
      10'b000000_00_0_1,
      10'b101111_00_0_1,
      10'b010100_10_0_1
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [5:0]    flash_addr;
   logic [DW-1:0] flash_rdata;
   logic          cfg_start;
   logic [1:0]    cfg_slot;
   logic          cfg_done = 1'b0;
   logic          host_wr = 1'b0;
   logic [DW-1:0] host_wdata = '0;
   logic [1:0]    stat_slot;
   logic          stat_fallback, stat_wdog_armed, stat_running;
   logic [DW-1:0] mem [64];

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   assign flash_rdata = mem[flash_addr];

   cfg_supervisor #(
      .DATA_W(DW), .N_USER(NU), .SLOT_AW(SAW), .WDOG_CYCLES(W), .CHECK_SUM(1),
      .MAGIC(MAGIC), .KEY0(K0), .KEY1(K1), .KEY2(K2)
   ) i_cfg_supervisor (
      .clk(clk), .rst_n(rst_n), .flash_addr(flash_addr), .flash_rdata(flash_rdata),
      .cfg_start(cfg_start), .cfg_slot(cfg_slot), .cfg_done(cfg_done),
      .host_wr(host_wr), .host_wdata(host_wdata), .stat_slot(stat_slot),
      .stat_fallback(stat_fallback), .stat_wdog_armed(stat_wdog_armed),
      .stat_running(stat_running)
   );

   task automatic chk_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load_flash(input logic [9:0] v);
      for (int a = 0; a < 64; a++) mem[a] = '0;
      for (int k = 1; k <= NU; k++) begin
         logic [1:0]  m;
         logic [15:0] w0, w1, w2;
         m  = v[4 + 2*(k-1) +: 2];
         w0 = (m == 2'd2) ? (MAGIC ^ 16'h0001) : MAGIC;
         w1 = 16'h0100 + 16'(k);
         w2 = ~(w0 ^ w1);
         if (m == 2'd3) w2 = w2 ^ 16'h0001;
         if (m != 2'd0) begin
            mem[k*16]     = w0;
            mem[k*16 + 1] = w1;
            mem[k*16 + 2] = w2;
         end
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; host_wr = 1'b0; cfg_done = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_start(output int s);
      for (int i = 0; i < 200; i++) begin
         if (cfg_start) break;
         @(negedge clk);
      end
      s = cfg_start ? int'(cfg_slot) : -1;
   endtask

   task automatic pulse_done();
      cfg_done = 1'b1;
      @(negedge clk);
      cfg_done = 1'b0;
   endtask

   task automatic host_write(input logic [15:0] d);
      host_wr = 1'b1; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic armed_len(output int n);
      n = 0;
      while (stat_wdog_armed && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired in bench");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
         end
      end
   end

   initial begin
      int s, n;
      logic [9:0] v;
      load_flash(VEC[0]);
      repeat (2) @(negedge clk);
      // R1 reset state
      chk_eq("R1 cfg_start", int'(cfg_start), 0);
      chk_eq("R1 stat_slot", int'(stat_slot), 0);
      chk_eq("R1 stat_fallback", int'(stat_fallback), 0);
      chk_eq("R1 stat_wdog_armed", int'(stat_wdog_armed), 0);
      chk_eq("R1 stat_running", int'(stat_running), 0);

      for (int t = 0; t < 6; t++) begin
         v = VEC[t];
         load_flash(v);
         do_reset();
         wait_start(s);
         chk_eq((v[3:2] != 0) ? "R2 first slot loaded" : "R3 fallback chosen", s, int'(v[3:2]));
         @(negedge clk);
         chk_eq("R2 start is one cycle", int'(cfg_start), 0);
         repeat (2) @(negedge clk);
         pulse_done();
         if (v[3:2] != 0) begin
            chk_eq("R4 armed after user load", int'(stat_wdog_armed), 1);
            if (v[1]) begin
               host_write(K0); host_write(K1); host_write(K2);
            end else begin
               armed_len(n);
               chk_eq("R4 window length", n, W);
               chk_eq("R4 fallback start", int'(cfg_start && cfg_slot == 0), 1);
               @(negedge clk);
               pulse_done();
            end
         end
         chk_eq("R5 running", int'(stat_running), 1);
         chk_eq("R5 slot held", int'(stat_slot), v[0] ? 0 : int'(v[3:2]));
         chk_eq("R3 fallback flag", int'(stat_fallback), int'(v[0]));
         chk_eq("R3 not armed", int'(stat_wdog_armed), 0);
      end

      // R6 wrong value restarts the sequence
      load_flash(10'b000001_00_0_0);
      do_reset();
      wait_start(s);
      @(negedge clk);
      pulse_done();
      host_write(K0); host_write(K1); host_write(16'h1234); host_write(K2);
      chk_eq("R6 broken sequence keeps armed", int'(stat_wdog_armed), 1);
      host_write(K0); host_write(K1); host_write(K2);
      chk_eq("R6 fresh sequence unlocks", int'(stat_running), 1);
      chk_eq("R6 slot", int'(stat_slot), 1);

      // R7 keys before arming do not count; then R9 after fallback
      do_reset();
      wait_start(s);
      @(negedge clk);
      host_write(K0); host_write(K1);
      pulse_done();
      host_write(K2);
      chk_eq("R7 early keys ignored", int'(stat_wdog_armed), 1);
      armed_len(n);
      chk_eq("R7 window ran out", n, W - 1);
      chk_eq("R7 fallback start", int'(cfg_start && cfg_slot == 0), 1);
      @(negedge clk);
      pulse_done();
      host_write(K0); host_write(K1); host_write(K2);
      pulse_done();
      @(negedge clk);
      chk_eq("R9 still running", int'(stat_running), 1);
      chk_eq("R9 no rearm", int'(stat_wdog_armed), 0);
      chk_eq("R9 fallback kept", int'(stat_fallback), 1);
      chk_eq("R9 slot zero", int'(stat_slot), 0);

      // R8 unlock on the last armed cycle wins
      do_reset();
      wait_start(s);
      @(negedge clk);
      pulse_done();
      host_write(K0); host_write(K1);
      repeat (W - 3) @(negedge clk);
      chk_eq("R8 still armed at last cycle", int'(stat_wdog_armed), 1);
      host_write(K2);
      chk_eq("R8 unlock beats timeout", int'(stat_running), 1);
      chk_eq("R8 no fallback", int'(stat_fallback), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule